// File: doc/BRIEF.md
# Compare Unit with Condition Flags

This block compares two operands by subtracting the second from the first. It discards the difference and keeps four status bits: zero, borrow (carry), sign and overflow. The flag set is the same whether the operands are meant as signed or unsigned numbers. The signed or unsigned reading is chosen only afterwards, when a 4-bit condition code selects one of ten relations. The relation's outcome is reported as a single taken bit.

A caller raises `in_vld` for one cycle with both operands and a condition code. On the next clock the registered flags, the taken bit and `out_vld` appear together. Strobes may arrive on consecutive cycles. Each one then produces its own result one cycle later. Between strobes the flags and the taken bit keep their last values.

The control is a two-state machine. `S_IDLE` means no result is being presented. `S_DONE` means a result computed from the previous cycle's strobe is on the outputs. The transition `ACCEPT` (in either state, `in_vld` high) leads to `S_DONE`. The transition `DRAIN` (in either state, `in_vld` low) leads to `S_IDLE`. Reset enters `S_IDLE`.

Top module: `cmp_flag_unit`

## Requirements
- R1: After reset `out_vld`, all four flags and `taken` are 0. `out_vld` is 1 in exactly the cycle after a cycle with `in_vld` high, and 0 otherwise.
- R2: The zero flag is 1 exactly when `op_a` equals `op_b`.
- R3: The carry flag is 1 exactly when `op_a` is below `op_b` read as unsigned numbers, i.e. the subtraction borrows.
- R4: The sign flag equals the top bit of (`op_a` − `op_b`) modulo 2^W.
- R5: The overflow flag is 1 exactly when the operands' top bits differ and the top bit of the difference differs from that of `op_a`.
- R6: Condition code 0 is taken on equal operands. Code 1 is taken on unequal operands.
- R7: Unsigned relations. Code 2 (below) is taken on C. Code 3 (above-or-equal) is taken on not C. Code 4 (below-or-equal) is taken on C or Z. Code 5 (above) is taken on neither C nor Z.
- R8: Signed relations, with L = S xor V. Code 6 (less) is taken on L. Code 7 (greater-or-equal) is taken on not L. Code 8 (less-or-equal) is taken on L or Z. Code 9 (greater) is taken on neither L nor Z.
- R9: Condition codes 10 to 15 are never taken, whatever the operands.
- R10: In a cycle without `in_vld`, the flags and `taken` keep their values, whatever is on the operand and code inputs.
- R11: With `op_a` = 0x80 and `op_b` = 0x00, code 5 (unsigned above) is taken and code 6 (signed less) is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Compare request strobe |
| op_a | input | W | Minuend |
| op_b | input | W | Subtrahend |
| cond | input | 4 | Relation code |
| out_vld | output | 1 | Result valid, one cycle after the strobe |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Borrow flag |
| flag_s | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |
| taken | output | 1 | Selected relation holds |

## Verification
Presenting one result and accepting the next request can happen in the same cycle. A strobe that arrives while `S_DONE` holds makes the machine take `ACCEPT` again and overwrite the registers. The bench provokes this with strobes on consecutive cycles whose operands and codes each give a different flag set and taken bit. It judges every cycle of the burst against that cycle's own predecessor request, so that a stale or merged result is seen.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic [3:0] {
        CC_EQ  = 4'd0,
        CC_NE  = 4'd1,
        CC_ULT = 4'd2,
        CC_UGE = 4'd3,
        CC_ULE = 4'd4,
        CC_UGT = 4'd5,
        CC_SLT = 4'd6,
        CC_SGE = 4'd7,
        CC_SLE = 4'd8,
        CC_SGT = 4'd9
    } cc_e;

    typedef struct packed {
        logic z;
        logic c;
        logic s;
        logic v;
    } flags_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } st_e;

endpackage

// File: rtl/cmp_sub.sv
module cmp_sub
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output flags_t       fl
);
    localparam int MSB = W - 1;

    logic [W:0]   wide;
    logic [W-1:0] diff;

    always_comb begin
        wide = {1'b0, a} - {1'b0, b};
        diff = wide[W-1:0];
        fl.z = (diff == '0);
        fl.c = wide[W];
        fl.s = diff[MSB];
        fl.v = (a[MSB] ^ b[MSB]) & (diff[MSB] ^ a[MSB]);
    end
endmodule

// File: rtl/cmp_cond_eval.sv
module cmp_cond_eval
    import cmp_pkg::*;
#(
    parameter int CW = 4
) (
    input  flags_t          fl,
    input  logic [CW-1:0]   cc,
    output logic            take
);
    logic lt;

    always_comb begin
        lt = fl.s ^ fl.v;
        unique case (cc)
            CC_EQ:   take = fl.z;
            CC_NE:   take = ~fl.z;
            CC_ULT:  take = fl.c;
            CC_UGE:  take = ~fl.c;
            CC_ULE:  take = fl.c | fl.z;
            CC_UGT:  take = ~(fl.c | fl.z);
            CC_SLT:  take = lt;
            CC_SGE:  take = ~lt;
            CC_SLE:  take = lt | fl.z;
            CC_SGT:  take = ~(lt | fl.z);
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   cond,
    output logic         out_vld,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_s,
    output logic         flag_v,
    output logic         taken
);
    localparam int CW = 4;

    st_e    state_q, state_d;
    flags_t fl_new, fl_q;
    logic   take_new, take_q;

    cmp_sub #(.W(W)) u_sub (
        .a  (op_a),
        .b  (op_b),
        .fl (fl_new)
    );

    cmp_cond_eval #(.CW(CW)) u_eval (
        .fl   (fl_new),
        .cc   (cond),
        .take (take_new)
    );

    // next state: ACCEPT on strobe, DRAIN otherwise
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = in_vld ? S_DONE : S_IDLE;
            S_DONE:  state_d = in_vld ? S_DONE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q   <= '0;
            take_q <= 1'b0;
        end else if (in_vld) begin
            fl_q   <= fl_new;
            take_q <= take_new;
        end
    end

    always_comb begin
        out_vld = (state_q == S_DONE);
        flag_z  = fl_q.z;
        flag_c  = fl_q.c;
        flag_s  = fl_q.s;
        flag_v  = fl_q.v;
        taken   = take_q;
    end
endmodule

// File: rtl/cmp_flag_unit_chk.sv
module cmp_flag_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_vld,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [3:0]   cond,
    input logic         out_vld,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_s,
    input logic         flag_v,
    input logic         taken
);
    AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R1
    AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld); // R1
    AST_ZERO_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (flag_z == ($past(op_a) == $past(op_b)))); // R2
    AST_BORROW_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (flag_c == ($past(op_a) < $past(op_b)))); // R3
    AST_EQ_FOLLOWS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cond == 4'd0) |=> (taken == flag_z)); // R6
    AST_RESERVED_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cond >= 4'd10) |=> !taken); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(flag_z) && $stable(flag_c) && $stable(flag_s)
                     && $stable(flag_v) && $stable(taken))); // R10
endmodule

bind cmp_flag_unit cmp_flag_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .op_a    (op_a),
    .op_b    (op_b),
    .cond    (cond),
    .out_vld (out_vld),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .flag_s  (flag_s),
    .flag_v  (flag_v),
    .taken   (taken)
);

// File: tb/cmp_flag_unit_tb_top.sv
module cmp_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [3:0] cond = '0;
    logic       out_vld, flag_z, flag_c, flag_s, flag_v, taken;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cmp_flag_unit #(.W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .cond(cond), .out_vld(out_vld), .flag_z(flag_z), .flag_c(flag_c),
        .flag_s(flag_s), .flag_v(flag_v), .taken(taken)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_flags(input logic [7:0] a, input logic [7:0] b);
        int sa, sb, sd;
        logic [7:0] d;
        sa = $signed(a);
        sb = $signed(b);
        sd = sa - sb;
        d = a - b;
        // order: z c s v
        return {a == b, a < b, d[7], (sd > 127) || (sd < -128)};
    endfunction

    function automatic logic exp_take(input logic [7:0] a, input logic [7:0] b, input logic [3:0] c);
        int sa, sb;
        sa = $signed(a);
        sb = $signed(b);
        case (c)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return a < b;
            4'd3: return a >= b;
            4'd4: return a <= b;
            4'd5: return a > b;
            4'd6: return sa < sb;
            4'd7: return sa >= sb;
            4'd8: return sa <= sb;
            4'd9: return sa > sb;
            default: return 1'b0;
        endcase
    endfunction

    // one strobe, result checked at next negedge
    task automatic one_cmp(input logic [7:0] a, input logic [7:0] b, input logic [3:0] c, input string req);
        logic [3:0] ef;
        @(negedge clk);
        in_vld = 1'b1; op_a = a; op_b = b; cond = c;
        @(negedge clk);
        in_vld = 1'b0;
        ef = exp_flags(a, b);
        chk({req, " R1 out_vld"}, out_vld, 1);
        chk({req, " R2 z"}, flag_z, ef[3]);
        chk({req, " R3 c"}, flag_c, ef[2]);
        chk({req, " R4 s"}, flag_s, ef[1]);
        chk({req, " R5 v"}, flag_v, ef[0]);
        chk({req, " taken"}, taken, exp_take(a, b, c));
        @(negedge clk);
        chk({req, " R1 out_vld drop"}, out_vld, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset out_vld", out_vld, 0);
        chk("R1 reset flags", {flag_z, flag_c, flag_s, flag_v}, 0);
        chk("R1 reset taken", taken, 0);
    endtask

    task automatic t_flags();
        one_cmp(8'h05, 8'h05, 4'd0, "R2 equal");
        one_cmp(8'h03, 8'h07, 4'd2, "R3 borrow");
        one_cmp(8'hF0, 8'h01, 4'd3, "R4 sign");
        one_cmp(8'h7F, 8'hFF, 4'd6, "R5 pos minus neg");
        one_cmp(8'h80, 8'h01, 4'd7, "R5 neg minus pos");
        one_cmp(8'h00, 8'h00, 4'd1, "R6 ne on equal");
    endtask

    task automatic t_codes();
        logic [7:0] pa [4] = '{8'h10, 8'h90, 8'h44, 8'hFF};
        logic [7:0] pb [4] = '{8'h90, 8'h10, 8'h44, 8'h00};
        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 10; c++)
                one_cmp(pa[p], pb[p], c[3:0], c < 2 ? "R6" : (c < 6 ? "R7" : "R8"));
    endtask

    task automatic t_reserved();
        for (int c = 10; c < 16; c++) begin
            one_cmp(8'h22, 8'h22, c[3:0], "R9 eq ops");
            one_cmp(8'h01, 8'h80, c[3:0], "R9 mixed ops");
        end
    endtask

    task automatic t_hold();
        one_cmp(8'h02, 8'h09, 4'd2, "R10 setup");
        for (int i = 0; i < 3; i++) begin
            op_a = 8'h55; op_b = 8'h55; cond = 4'd3;
            @(negedge clk);
            chk("R10 out_vld", out_vld, 0);
            chk("R10 flags held", {flag_z, flag_c, flag_s, flag_v}, {1'b0, 1'b1, 1'b1, 1'b0});
            chk("R10 taken held", taken, 1);
        end
    endtask

    task automatic t_corner();
        one_cmp(8'h80, 8'h00, 4'd5, "R11 unsigned above");
        chk("R11 above taken", taken, 1);
        one_cmp(8'h80, 8'h00, 4'd6, "R11 signed less");
        chk("R11 less taken", taken, 1);
    endtask

    // back-to-back strobes: present and accept in the same cycle
    task automatic t_burst();
        logic [7:0] ba [5] = '{8'h01, 8'h80, 8'h7F, 8'hAA, 8'h00};
        logic [7:0] bb [5] = '{8'h02, 8'h7F, 8'h80, 8'hAA, 8'hFF};
        logic [3:0] bc [5] = '{4'd2, 4'd6, 4'd9, 4'd4, 4'd5};
        logic [3:0] ef;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            in_vld = 1'b1; op_a = ba[i]; op_b = bb[i]; cond = bc[i];
            @(negedge clk);
            ef = exp_flags(ba[i], bb[i]);
            chk("R1 burst out_vld", out_vld, 1);
            chk("R2 R3 R4 R5 burst flags", {flag_z, flag_c, flag_s, flag_v}, ef);
            chk("R7 R8 burst taken", taken, exp_take(ba[i], bb[i], bc[i]));
        end
        in_vld = 1'b0;
        @(negedge clk);
        chk("R1 burst end", out_vld, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flags();
        t_codes();
        t_reserved();
        t_hold();
        t_corner();
        t_burst();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule